// File: doc/BRIEF.md
# Serial DAC Control Front End

This block is the digital side of a 12-bit voltage-output converter. A host writes 16-bit words over a three-wire serial link: a serial clock, a data line, and an active-low frame strobe. While the strobe is low, the block takes one data bit on each falling edge of the serial clock, most significant bit first. When the strobe returns high after a complete word, the word is split into a 12-bit straight-binary code and a 2-bit output-impedance select, and both are registered at once.

All three link inputs are sampled by a faster system clock through synchronizer flops. Serial clock edges are found from the synchronized samples. The last stage of the shift register is driven out as a daisy-chain output. A companion enable, high only while the synchronized strobe is low, tells the pad to drive that output. Several devices can therefore share the clock and strobe and pass words down a chain. A power-on reset and an asynchronous active-low clear both return every register to zero.

Top module: `sdac_front`

## Requirements
- R1: While the synchronized strobe is low, each falling edge of the serial clock shifts the data bit into a 16-bit shift register, most significant bit first.
- R2: When the strobe rises after at least 16 falling edges in the frame, `code_o` takes bits 11:0 and `pd_mode_o` takes bits 13:12 of the last 16 bits shifted in. If more than 16 bits arrived, only the last 16 count.
- R3: The mode field is passed through unchanged: 00 is active output, 01 is powered down with 1 kΩ to ground, 10 is powered down with 100 kΩ, 11 is powered down and floating.
- R4: Bits 15:14 of the word have no effect on either output.
- R5: Outputs change only at the end of a complete frame, or on reset or clear.
- R6: A frame that ends after fewer than 16 falling edges is dropped, and both outputs keep their values.
- R7: A word that selects a power-down mode still loads its 12-bit code. `code_o` is not forced to zero while powered down.
- R8: After power-on reset, `code_o`, `pd_mode_o`, `sdo_o` and `sdo_en_o` are all zero.
- R9: Pulling `clr_n` low zeroes `code_o`, `pd_mode_o` and the shift register at once, without waiting for a clock edge.
- R10: A frame that was in progress when the clear arrived is dropped. The next complete frame after the clear loads normally on the rise of the strobe.
- R11: `sdo_o` is the last stage of the shift register, so it repeats the data line 16 falling edges later. `sdo_en_o` is high only while the synchronized strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| clr_n | input | 1 | Active-low clear, asynchronous |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdin_i | input | 1 | Serial data in |
| sync_n_i | input | 1 | Active-low frame strobe |
| code_o | output | 12 | Registered converter code |
| pd_mode_o | output | 2 | Registered output-impedance select |
| sdo_o | output | 1 | Daisy-chain serial data out |
| sdo_en_o | output | 1 | Drive enable for the daisy-chain pad |

## Verification
The bench sends short frames and overlong frames. A design that counted bits wrongly would latch a partial word on a short frame, or keep the oldest 16 bits of a long one. It writes words with the top two bits set and with every power-down mode. These catch a decoder that leaks the ignored bits into the code, and a datapath that zeroes the code while powered down. It checks the daisy-chain output against bits sent 16 edges earlier, which exposes an off-by-one in the shift depth. It also clears the block partway through a frame and then raises the strobe. A design that kept its bit count across the clear would load a word made from bits received before and after it.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
package sdac_pkg;
  localparam int FRAME_W  = 16;
  localparam int CODE_W   = 12;
  localparam int MODE_W   = 2;
  localparam int MODE_LSB = CODE_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef enum logic [MODE_W-1:0] {
    PD_ACTIVE = 2'b00,
    PD_R1K    = 2'b01,
    PD_R100K  = 2'b10,
    PD_OPEN   = 2'b11
  } pd_mode_e;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  function automatic code_t frame_code(frame_t f);
    return f[CODE_W-1:0];
  endfunction

  function automatic pd_mode_e frame_mode(frame_t f);
    return pd_mode_e'(f[MODE_LSB +: MODE_W]);
  endfunction

  function automatic frame_t frame_shift(frame_t f, logic b);
    return {f[FRAME_W-2:0], b};
  endfunction

  function automatic logic cnt_full(cnt_t c);
    return c == cnt_t'(FRAME_W);
  endfunction

  function automatic cnt_t cnt_step(cnt_t c, logic bump);
    if (bump && !cnt_full(c)) return c + cnt_t'(1);
    return c;
  endfunction
endpackage

// File: rtl/sdac_sync.sv
`timescale 1ns/1ps
module sdac_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
`timescale 1ns/1ps
module sdac_shifter
  import sdac_pkg::*;
(
  input  logic   clk,
  input  logic   arst_n,
  input  logic   sclk_s,
  input  logic   sdin_s,
  input  logic   sync_s,
  output frame_t frame_o,
  output cnt_t   cnt_o,
  output logic   shift_evt_o,
  output logic   done_evt_o,
  output logic   short_evt_o
);
  logic sclk_d;
  logic sync_d;
  logic sync_rise;

  assign shift_evt_o = sclk_d & ~sclk_s & ~sync_s;
  assign sync_rise   = sync_s & ~sync_d;
  assign done_evt_o  = sync_rise & cnt_full(cnt_o);
  assign short_evt_o = sync_rise & ~cnt_full(cnt_o);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sclk_d  <= 1'b1;
      sync_d  <= 1'b1;
      cnt_o   <= '0;
      frame_o <= '0;
    end else begin
      sclk_d <= sclk_s;
      sync_d <= sync_s;
      if (sync_s) cnt_o <= '0;
      else        cnt_o <= cnt_step(cnt_o, shift_evt_o);
      if (shift_evt_o) frame_o <= frame_shift(frame_o, sdin_s);
    end
  end
endmodule

// File: rtl/sdac_latch.sv
`timescale 1ns/1ps
module sdac_latch
  import sdac_pkg::*;
(
  input  logic     clk,
  input  logic     arst_n,
  input  logic     load_i,
  input  frame_t   frame_i,
  output code_t    code_o,
  output pd_mode_e mode_o
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      code_o <= '0;
      mode_o <= PD_ACTIVE;
    end else if (load_i) begin
      code_o <= frame_code(frame_i);
      mode_o <= frame_mode(frame_i);
    end
  end
endmodule

// File: rtl/sdac_front.sv
`timescale 1ns/1ps
module sdac_front
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              sync_n_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] pd_mode_o,
  output logic              sdo_o,
  output logic              sdo_en_o
);
  localparam int          IN_W   = 3;
  localparam logic [2:0]  IN_RST = 3'b101;

  logic        arst_n;
  logic [2:0]  in_s;
  logic        sclk_s, sdin_s, sync_s;
  frame_t      frame_q;
  cnt_t        bit_cnt;
  logic        shift_evt, done_evt, short_evt;
  pd_mode_e    mode_q;

  assign arst_n = rst_n & clr_n;

  sdac_sync #(
    .WIDTH  (IN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(IN_RST)
  ) u_sync (
    .clk   (clk),
    .arst_n(arst_n),
    .d     ({sclk_i, sdin_i, sync_n_i}),
    .q     (in_s)
  );

  assign {sclk_s, sdin_s, sync_s} = in_s;

  sdac_shifter u_shift (
    .clk        (clk),
    .arst_n     (arst_n),
    .sclk_s     (sclk_s),
    .sdin_s     (sdin_s),
    .sync_s     (sync_s),
    .frame_o    (frame_q),
    .cnt_o      (bit_cnt),
    .shift_evt_o(shift_evt),
    .done_evt_o (done_evt),
    .short_evt_o(short_evt)
  );

  sdac_latch u_latch (
    .clk    (clk),
    .arst_n (arst_n),
    .load_i (done_evt),
    .frame_i(frame_q),
    .code_o (code_o),
    .mode_o (mode_q)
  );

  assign pd_mode_o = mode_q;
  assign sdo_o     = frame_q[FRAME_W-1];
  assign sdo_en_o  = ~sync_s;
endmodule

// File: rtl/sdac_front_chk.sv
`timescale 1ns/1ps
module sdac_front_chk
  import sdac_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              arst_n,
  input logic              shift_evt,
  input logic              done_evt,
  input logic              short_evt,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [FRAME_W-1:0] frame_q,
  input logic [CODE_W-1:0] code_o,
  input logic [MODE_W-1:0] pd_mode_o,
  input logic              sdo_o
);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!arst_n)
    bit_cnt <= CNT_W'(FRAME_W));

  assert_load_value_R2: assert property (@(posedge clk) disable iff (!arst_n)
    done_evt |=> (code_o == $past(frame_q[CODE_W-1:0])) &&
                 (pd_mode_o == $past(frame_q[MODE_LSB +: MODE_W])));

  assert_hold_between_frames_R5: assert property (@(posedge clk) disable iff (!arst_n)
    !$past(done_evt) |-> ($stable(code_o) && $stable(pd_mode_o)));

  assert_short_discard_R6: assert property (@(posedge clk) disable iff (!arst_n)
    short_evt |=> ($stable(code_o) && $stable(pd_mode_o)));

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (code_o == '0) && (pd_mode_o == '0) && !sdo_o);

  assert_sdo_delay_R11: assert property (@(posedge clk) disable iff (!arst_n)
    shift_evt |=> sdo_o == $past(frame_q[FRAME_W-2]));
endmodule

bind sdac_front sdac_front_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_n    (clr_n),
  .arst_n   (arst_n),
  .shift_evt(shift_evt),
  .done_evt (done_evt),
  .short_evt(short_evt),
  .bit_cnt  (bit_cnt),
  .frame_q  (frame_q),
  .code_o   (code_o),
  .pd_mode_o(pd_mode_o),
  .sdo_o    (sdo_o)
);

// File: tb/sdac_front_bench.sv
`timescale 1ns/1ps
module sdac_front_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, clr_n = 1'b1;
  logic sclk = 1'b1, sdin = 1'b0, sync_n = 1'b1;
  logic [11:0] code;
  logic [1:0]  mode;
  logic        sdo, sdo_en;

  sdac_front u_sdac_front (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
    .sclk_i(sclk), .sdin_i(sdin), .sync_n_i(sync_n),
    .code_o(code), .pd_mode_o(mode), .sdo_o(sdo), .sdo_en_o(sdo_en)
  );

  int n_run = 0, n_fail = 0;
  bit cmp_on = 0, finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: two-sample input delay, edge history, bit queue.
  bit    h_sclk[$], h_sdin[$], h_sync[$];
  bit    m_bits[$];
  int    m_cnt;
  int    m_code, m_mode;

  function automatic int last16();
    int v = 0;
    for (int i = 0; i < 16; i++) v = (v << 1) | m_bits[m_bits.size() - 16 + i];
    return v;
  endfunction

  task automatic model_clear();
    h_sclk = '{1, 1, 1}; h_sync = '{1, 1, 1}; h_sdin = '{0, 0, 0};
    m_bits.delete();
    for (int i = 0; i < 16; i++) m_bits.push_back(0);
    m_cnt = 0; m_code = 0; m_mode = 0;
  endtask

  always @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n || !clr_n) model_clear();
    else begin
      // h_x[0] newest sample, h_x[1] seen value, h_x[2] previous seen value
      bit fall, rise;
      fall = h_sclk[2] && !h_sclk[1] && !h_sync[1];
      rise = h_sync[1] && !h_sync[2];
      if (rise && m_cnt == 16) begin
        m_code = last16() & 12'hFFF;
        m_mode = (last16() >> 12) & 3;
      end
      if (h_sync[1]) m_cnt = 0;
      else if (fall && m_cnt < 16) m_cnt++;
      if (fall) begin
        m_bits.push_back(h_sdin[1]);
        void'(m_bits.pop_front());
      end
      h_sclk.push_front(sclk); void'(h_sclk.pop_back());
      h_sdin.push_front(sdin); void'(h_sdin.pop_back());
      h_sync.push_front(sync_n); void'(h_sync.pop_back());
    end
  end

  always @(posedge clk) begin
    #1;
    if (cmp_on && !finished) begin
      chk(code == 12'(m_code), "R2", "model code", code, m_code);
      chk(mode == 2'(m_mode), "R3", "model mode", mode, m_mode);
      chk(sdo == m_bits[0], "R11", "model sdo", sdo, m_bits[0]);
      chk(sdo_en == !h_sync[1], "R11", "model sdo_en", sdo_en, !h_sync[1]);
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    @(negedge clk); sdin = b; sclk = 1'b1;
    wait_clk(4); sclk = 1'b0;
    wait_clk(3);
  endtask

  task automatic write_bits(logic [31:0] w, int nbits);
    @(negedge clk); sync_n = 1'b0;
    wait_clk(3);
    for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
    wait_clk(3); sync_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic expect_out(int c, int m, string req);
    chk(code == 12'(c), req, "code", code, c);
    chk(mode == 2'(m), req, "mode", mode, m);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_clear();
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(1);
    // R8 reset state
    chk(code == 0 && mode == 0, "R8", "reset outputs", {mode, code}, 0);
    chk(!sdo && !sdo_en, "R8", "reset sdo/sdo_en", {sdo, sdo_en}, 0);
    cmp_on = 1;

    write_bits(32'h0ABC, 16);               // R1 R2 normal write
    expect_out(12'hABC, 0, "R2");
    write_bits(32'hC123, 16);               // R4 top bits ignored
    expect_out(12'h123, 0, "R4");
    write_bits(32'h1555, 16);               // R7 R3 power-down 1k keeps code
    expect_out(12'h555, 1, "R7");
    write_bits(32'h2AAA, 16);               // R3 100k
    expect_out(12'hAAA, 2, "R3");
    write_bits(32'hFFFF, 16);               // R3 R7 floating, full scale
    expect_out(12'hFFF, 3, "R7");
    write_bits(32'h0000, 16);               // R3 back to active, zero
    expect_out(0, 0, "R3");
    write_bits(32'h0777, 16);
    expect_out(12'h777, 0, "R1");

    write_bits(32'h3F5, 10);                // R6 short frame dropped
    expect_out(12'h777, 0, "R6");
    write_bits(32'h0, 15);                  // R6 one bit short
    expect_out(12'h777, 0, "R6");
    write_bits(32'h000F_1234, 20);          // R2 last 16 of a long frame
    expect_out(12'h234, 1, "R2");
    wait_clk(20);                           // R5 idle, no change
    expect_out(12'h234, 1, "R5");
    chk(!sdo_en, "R11", "sdo_en idle", sdo_en, 0);

    // R11 daisy chain: 32-bit stream, sdo repeats bit k-16
    begin
      logic [31:0] w = 32'hA5C3_0F96;
      @(negedge clk); sync_n = 1'b0;
      wait_clk(3);
      for (int k = 0; k < 32; k++) begin
        @(negedge clk); sdin = w[31-k]; sclk = 1'b1;
        wait_clk(4);
        if (k >= 16) chk(sdo == w[31-(k-16)], "R11", "sdo delay", sdo, w[31-(k-16)]);
        chk(sdo_en, "R11", "sdo_en in frame", sdo_en, 1);
        sclk = 1'b0;
        wait_clk(3);
      end
      wait_clk(3); sync_n = 1'b1;
      wait_clk(6);
      expect_out(12'hF96, 0, "R2");
    end

    // R9 R10 clear in the middle of a frame
    @(negedge clk); sync_n = 1'b0;
    wait_clk(3);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    @(negedge clk); sclk = 1'b1;
    wait_clk(4);
    #1 clr_n = 1'b0;
    #0.5;
    chk(code == 0 && mode == 0, "R9", "async clear outputs", {mode, code}, 0);
    chk(!sdo, "R9", "async clear shift reg", sdo, 0);
    wait_clk(3);
    clr_n = 1'b1;
    wait_clk(3);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    wait_clk(3); sync_n = 1'b1;
    wait_clk(6);
    expect_out(0, 0, "R10");
    write_bits(32'h2DEF, 16);
    expect_out(12'hDEF, 2, "R10");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule